// File: doc/BRIEF.md
# Three-Wire Serial Byte Memory Slave

This block is the slave end of a three-wire serial memory with an active-high select, a serial clock, one serial input and one serial output. It holds a 512-byte array in internal registers. A frame starts with a 1 start bit, followed by a two-bit opcode and a 9-bit byte address, all sent most significant bit first. The block can read one byte or a run of bytes, switch write permission on and off, write one or more bytes into a 16-byte page, erase one byte, erase the whole array, and fill the whole array with one byte value.

All array updates are self-timed. The frame only stages the update. The update starts when select falls, and the block then stays busy for `PROG_CYCLES` system clocks without needing any serial clock. While the device is busy and selected, the output shows ready/busy status. The serial clock is oversampled by the system clock, and all serial activity happens on its rising edge.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the array holds 0xFF in every byte and writes are disabled. `dout` is 0 whenever `cs` is low. When the device is selected, not busy and no read is in progress, `dout` is 1.
- R2: A read frame is start bit 1, opcode bits 1,0 and a 9-bit address. On the serial clock rising edge that samples the last address bit, `dout` becomes a dummy 0. Each later rising edge shifts out one data bit, MSB first.
- R3: While select stays high after a read frame, output continues into the next higher address with no gap. After address 511 it wraps to address 0.
- R4: Opcode 0,0 followed by address bits 1,1 enables writes, and 0,0 followed by 0,0 disables them. Write, erase, erase-all and write-all frames sent while writes are disabled change nothing and start no busy cycle. Reads work in either state.
- R5: A write frame is start bit 1, opcode 0,1, a 9-bit address and whole data bytes. Each byte goes to the next address. Only the low 4 address bits advance, so after xxxxx1111 the next byte lands at xxxxx0000 of the same page.
- R6: Buffered page bytes reach the array only after select falls. The update is one self-timed cycle. `dout` reads 0 when selected during that cycle and returns to 1 after about `PROG_CYCLES` system clocks.
- R7: Start bit 1, opcode 1,1 and an address set that byte to 0xFF when select falls.
- R8: Opcode 0,0 followed by address bits 1,0 sets every byte to 0xFF when select falls.
- R9: Opcode 0,0 followed by address bits 0,1, then one data byte, writes that byte to every location when select falls. No prior erase is needed.
- R10: While a self-timed cycle runs, serial clock edges and data are ignored. No command can start, and `dout` shows busy (0) while selected.
- R11: Select going low clears any partly received frame and drops partial data bytes. The next operation needs a full new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; data is captured and shifted on its rising edge |
| di | input | 1 | Serial data into the device |
| dout | output | 1 | Serial read data, or ready (1) / busy (0) status |

## Verification
The bench writes a page starting two bytes before a page boundary. A design whose pointer carried into the upper address bits would put the third byte in the next page rather than at the page start. It runs a continuous read across address 511. A design missing the wrap would return an out-of-range byte instead of address 0. It sends writes and an erase while writes are disabled, and checks that no busy cycle starts and no byte changes. It drops select in the middle of a data byte and checks that nothing is committed, and it clocks a frame during busy and checks that the device does not enter a read.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int AW = 9,
  parameter int PW = 4,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int FW    = AW + 2;
  localparam int NW    = $clog2(FW + 1);
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_READ, S_WDATA, S_DONE} st_t;
  typedef enum logic [2:0] {P_NONE, P_ERASE, P_ERAL, P_WRAL, P_PAGE} pend_t;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pmask;
  st_t             st;
  pend_t           pend;
  logic            sk_q, cs_q, wen, is_wral, dout_r;
  logic [FW-1:0]   sh;
  logic [NW-1:0]   cnt;
  logic [2:0]      bitc;
  logic [AW-1:0]   addr;
  logic [7:0]      rsh, wsh, wdata;
  logic [CW-1:0]   bcnt;

  wire            busy    = bcnt != '0;
  wire            edge_ok = cs & sk & ~sk_q & ~busy;
  wire            cs_fall = cs_q & ~cs;
  wire [FW-1:0]   frame   = {sh[FW-2:0], di};
  wire [AW-1:0]   fa      = frame[AW-1:0];
  wire [7:0]      byte_in = {wsh[6:0], di};
  wire [AW-1:0]   addr_n  = addr + 1'b1;

  assign dout = cs & ((st == S_READ) ? dout_r : ~busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
      pmask <= '0; st <= S_IDLE; pend <= P_NONE;
      sk_q <= 1'b0; cs_q <= 1'b0; wen <= 1'b0; is_wral <= 1'b0; dout_r <= 1'b0;
      sh <= '0; cnt <= '0; bitc <= '0; addr <= '0;
      rsh <= '0; wsh <= '0; wdata <= '0; bcnt <= '0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      if (busy) bcnt <= bcnt - 1'b1;
      if (!cs) begin
        st <= S_IDLE;
        if (cs_fall && !busy && pend != P_NONE) begin
          bcnt <= CW'(PROG_CYCLES);
          case (pend)
            P_ERASE: mem[addr] <= 8'hFF;
            P_ERAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            P_WRAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
            P_PAGE:  for (int i = 0; i < PAGE; i++)
                       if (pmask[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
            default: ;
          endcase
        end
        pend  <= P_NONE;
        pmask <= '0;
      end else if (edge_ok) begin
        case (st)
          S_IDLE: if (di) begin st <= S_CMD; cnt <= '0; end
          S_CMD: begin
            sh  <= frame;
            cnt <= cnt + 1'b1;
            if (cnt == NW'(FW - 1)) begin
              addr <= fa;
              bitc <= '0;
              case (frame[FW-1 -: 2])
                2'b10: begin st <= S_READ; rsh <= mem[fa]; dout_r <= 1'b0; end
                2'b01: begin st <= S_WDATA; is_wral <= 1'b0; end
                2'b11: begin st <= S_DONE; if (wen) pend <= P_ERASE; end
                default: begin
                  st <= S_DONE;
                  case (fa[AW-1 -: 2])
                    2'b11: wen <= 1'b1;
                    2'b00: wen <= 1'b0;
                    2'b01: begin st <= S_WDATA; is_wral <= 1'b1; end
                    default: if (wen) pend <= P_ERAL;
                  endcase
                end
              endcase
            end
          end
          S_READ: begin
            dout_r <= rsh[7];
            if (bitc == 3'd7) begin
              addr <= addr_n;
              rsh  <= mem[addr_n];
              bitc <= '0;
            end else begin
              rsh  <= {rsh[6:0], 1'b0};
              bitc <= bitc + 1'b1;
            end
          end
          S_WDATA: begin
            wsh  <= byte_in;
            bitc <= bitc + 1'b1;
            if (bitc == 3'd7) begin
              if (is_wral) begin
                wdata <= byte_in;
                st    <= S_DONE;
                if (wen) pend <= P_WRAL;
              end else begin
                pbuf[addr[PW-1:0]]  <= byte_in;
                pmask[addr[PW-1:0]] <= 1'b1;
                addr[PW-1:0]        <= addr[PW-1:0] + 1'b1;
                if (wen) pend <= P_PAGE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module mw_eeprom_chk #(
  parameter int AW = 9,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          dout,
  input logic          busy,
  input logic          wen,
  input logic [2:0]    st,
  input logic [2:0]    pend,
  input logic [AW-1:0] addr
);
  // R10
  busy_dout_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && busy) |-> !dout);

  // R10
  busy_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == 3'd0));

  // R4
  pend_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != 3'd0) |-> wen);

  // R6
  busy_starts_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs));

  // R11
  deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (st == 3'd0));

  // R5
  page_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |=> (addr[AW-1:PW] == $past(addr[AW-1:PW])));

  // R1
  idle_dout_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout);
endmodule

bind mw_eeprom mw_eeprom_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .busy(busy), .wen(wen),
  .st(st), .pend(pend), .addr(addr)
);

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int PROG = 40;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mw_eeprom #(.AW(9), .PW(4), .PROG_CYCLES(PROG)) u_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel();
    @(negedge clk); cs = 1'b1; @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); cs = 1'b0; di = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic o);
    @(negedge clk); di = b;
    @(negedge clk); sk = 1'b1;
    repeat (2) @(negedge clk); o = dout; sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [8:0] a, output logic o);
    bitx(1'b1, o);
    for (int i = 1; i >= 0; i--) bitx(op[i], o);
    for (int i = 8; i >= 0; i--) bitx(a[i], o);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic o;
    for (int i = 7; i >= 0; i--) bitx(v[i], o);
  endtask

  task automatic read_seq(input logic [8:0] a, input int n, input logic [7:0] exp [4], input string tag);
    logic o;
    logic [7:0] v;
    sel();
    cmd(2'b10, a, o);
    check(o == 1'b0, {tag, " dummy bit"}, o, 0);
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int i = 0; i < 8; i++) begin
        bitx(1'b0, o);
        v = {v[6:0], o};
      end
      check(v == exp[k], tag, v, exp[k]);
    end
    desel();
  endtask

  task automatic special(input logic [1:0] code);
    logic o;
    sel(); cmd(2'b00, {code, 7'b0}, o); desel();
  endtask

  task automatic expect_busy_cycle(input string tag);
    int n;
    sel();
    check(dout == 1'b0, {tag, " busy seen"}, dout, 0);
    n = 0;
    while (dout == 1'b0 && n < PROG + 20) begin
      @(negedge clk); n++;
    end
    check(dout == 1'b1 && n >= PROG - 12 && n <= PROG, {tag, " busy length"}, n, PROG);
    desel();
  endtask

  task automatic expect_no_busy(input string tag);
    sel();
    check(dout == 1'b1, {tag, " no busy"}, dout, 1);
    desel();
  endtask

  task automatic t_reset();
    logic [7:0] e [4];
    check(dout == 1'b0, "R1 dout deselected", dout, 0);
    sel();
    check(dout == 1'b1, "R1 ready when selected", dout, 1);
    desel();
    e = '{8'hFF, 8'hFF, 8'h00, 8'h00};
    read_seq(9'h005, 2, e, "R1 R2 erased read");
  endtask

  task automatic t_disabled();
    logic o;
    logic [7:0] e [4];
    sel(); cmd(2'b01, 9'h003, o); send_byte(8'h12); desel();
    expect_no_busy("R4 write disabled");
    e = '{8'hFF, 8'h00, 8'h00, 8'h00};
    read_seq(9'h003, 1, e, "R4 write ignored");
  endtask

  task automatic t_page();
    logic o;
    logic [7:0] e [4];
    special(2'b11);
    sel(); cmd(2'b01, 9'h01E, o);
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
    desel();
    expect_busy_cycle("R6 page commit");
    e = '{8'hA1, 8'hB2, 8'hFF, 8'h00};
    read_seq(9'h01E, 3, e, "R5 R3 page then next page");
    e = '{8'hC3, 8'hFF, 8'h00, 8'h00};
    read_seq(9'h010, 2, e, "R5 page wrap");
  endtask

  task automatic t_wrap();
    logic o;
    logic [7:0] e [4];
    sel(); cmd(2'b01, 9'h1FF, o); send_byte(8'h5A); desel();
    expect_busy_cycle("R6 single byte");
    sel(); cmd(2'b01, 9'h000, o); send_byte(8'h3C); desel();
    expect_busy_cycle("R6 single byte 0");
    e = '{8'h5A, 8'h3C, 8'hFF, 8'h00};
    read_seq(9'h1FF, 3, e, "R3 array wrap");
  endtask

  task automatic t_erase();
    logic o;
    logic [7:0] e [4];
    sel(); cmd(2'b11, 9'h01F, o); desel();
    expect_busy_cycle("R7 erase");
    e = '{8'hA1, 8'hFF, 8'h00, 8'h00};
    read_seq(9'h01E, 2, e, "R7 erased byte");
  endtask

  task automatic t_abort();
    logic o;
    logic [7:0] e [4];
    sel(); cmd(2'b01, 9'h040, o);
    for (int i = 0; i < 4; i++) bitx(1'b0, o);
    desel();
    expect_no_busy("R11 partial byte");
    sel(); bitx(1'b1, o); bitx(1'b1, o); desel();
    e = '{8'hFF, 8'h00, 8'h00, 8'h00};
    read_seq(9'h040, 1, e, "R11 fresh frame after abort");
  endtask

  task automatic t_wral();
    logic o;
    logic [7:0] e [4];
    sel(); cmd(2'b00, 9'h080, o); send_byte(8'h69); desel();
    expect_busy_cycle("R9 write all");
    e = '{8'h69, 8'h69, 8'h00, 8'h00};
    read_seq(9'h1FF, 2, e, "R9 filled ends");
    e = '{8'h69, 8'h00, 8'h00, 8'h00};
    read_seq(9'h123, 1, e, "R9 filled middle");
  endtask

  task automatic t_eral_busy();
    logic o;
    logic [7:0] e [4];
    special(2'b10);
    sel();
    check(dout == 1'b0, "R10 busy after erase all", dout, 0);
    bitx(1'b1, o); check(o == 1'b0, "R10 sk ignored while busy", o, 0);
    bitx(1'b1, o); bitx(1'b0, o);
    repeat (PROG) @(negedge clk);
    check(dout == 1'b1, "R10 ready and no frame started", dout, 1);
    desel();
    e = '{8'hFF, 8'hFF, 8'h00, 8'h00};
    read_seq(9'h1FF, 2, e, "R8 erase all");
  endtask

  task automatic t_wds();
    logic o;
    logic [7:0] e [4];
    sel(); cmd(2'b01, 9'h007, o); send_byte(8'h77); desel();
    expect_busy_cycle("R6 before disable");
    special(2'b00);
    sel(); cmd(2'b11, 9'h007, o); desel();
    expect_no_busy("R4 erase disabled");
    special(2'b10);
    expect_no_busy("R4 erase all disabled");
    e = '{8'h77, 8'h00, 8'h00, 8'h00};
    read_seq(9'h007, 1, e, "R4 read while disabled");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_page();
    t_wrap();
    t_erase();
    t_abort();
    t_wral();
    t_eral_busy();
    t_wds();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule